// File: doc/BRIEF.md
# Majority-Voting Asynchronous Serial Receiver

This block receives asynchronous serial frames using a baud tick that runs at sixteen times the bit rate. While idle, its bit-phase counter is held at zero. A falling edge on the synchronized serial line starts the counter, but only when receive is enabled. Each bit is sampled on three consecutive ticks, and a 2-of-3 vote decides its value. The voted value is then committed on the tick that follows.

A start bit that fails the vote sends the receiver back to idle without any trace. A good start bit is followed by seven or eight data bits, sent least significant bit first. After the data comes an optional even or odd parity bit, then the first stop bit.

Errors found while a frame is being received are not shown on the outputs yet. They stay pending until the frame is copied into the receive buffer. In that same clock edge the receive-complete pulse fires, and the framing, parity and overrun flags are all updated together. A read strobe tells the block that the buffer has been consumed. Baud tick generation and any bus interface sit outside this block.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, `rx_byte` is 0x00 and `rx_done`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: A frame is started only by a high-to-low transition on the synchronized line while `rx_en` is 1. A frame sent while `rx_en` is 0 produces no `rx_done` and leaves `rx_byte` unchanged.
- R3: Each bit takes the majority of three samples taken at phase counts 6, 7 and 8, and is committed at count 9. A disturbance that corrupts one sample does not change the bit. A disturbance covering all three samples does change it.
- R4: Data is received least significant bit first. `cfg_len8`=1 selects 8 data bits. `cfg_len8`=0 selects 7 data bits, and `rx_byte[7]` then reads 0.
- R5: A start bit with fewer than two low samples returns the receiver to idle. This produces no `rx_done` and no change to `rx_byte` or any flag, and a following valid frame is received normally.
- R6: Only the first stop bit is checked. If its voted value is 0, `err_frame` is 1 with the frame's `rx_done`.
- R7: `cfg_par` encoding: 2'b01 means even parity, 2'b10 means odd parity, and 2'b00 or 2'b11 means no parity bit. When a parity bit is received and does not match the selected parity, `err_parity` is 1 with the frame's `rx_done`.
- R8: If a frame completes while the previous buffer contents are still unread, `err_overrun` is 1 with its `rx_done`, and `rx_byte` takes the new data.
- R9: A `rd_strobe` pulse marks the buffer as read. The next completed frame then reports `err_overrun` as 0.
- R10: `err_frame`, `err_parity` and `err_overrun` change only in the cycle in which `rx_done` is 1. Errors detected during the stop bit do not appear before that cycle.
- R11: `rx_byte` and the flags hold their values between frames. A clean frame clears any flags that were set before.
- R12: `rx_done` is a single-cycle pulse, issued once per accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; gates the start of a frame |
| baud_tick | input | 1 | One-cycle tick at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial data line, idle high |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par | input | 2 | Parity select: 01 even, 10 odd, 00/11 none |
| rd_strobe | input | 1 | Buffer consumed |
| rx_byte | output | 8 | Receive buffer |
| rx_done | output | 1 | Receive-complete pulse |
| err_frame | output | 1 | Stop bit was 0 in the last frame |
| err_parity | output | 1 | Parity mismatch in the last frame |
| err_overrun | output | 1 | Last frame overwrote unread data |

## Verification
The bench uses the default parameters: sixteen phases per bit and a two-stage synchronizer. It holds `baud_tick` high continuously, so one bit lasts exactly sixteen clocks. Because of this, a disturbance on the line can be placed at an exact clock offset inside a bit. That makes it possible to corrupt exactly one vote sample, or all three, and to fail a start bit on purpose. Both data lengths, all three parity settings and both stop-bit values are covered. The bench also checks the moment at which the flags change, against the value they held one cycle before the completion pulse.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_POST
    } rx_state_e;

    typedef struct packed {
        logic frame;
        logic parity;
    } rx_err_t;

    function automatic logic majority3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    // true when data plus received parity bit disagree with the chosen sense
    function automatic logic parity_bad(input logic [7:0] d, input logic pbit,
                                        input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/urx_sampler.sv
module urx_sampler #(
    parameter int OSR   = 16,
    parameter int CNT_W = $clog2(OSR)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic din,
    output logic voted,
    output logic shift_stb
);
    localparam logic [CNT_W-1:0] SMP_FIRST = CNT_W'(OSR / 2 - 2);
    localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] SHIFT_AT  = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt;
    logic [2:0]       samp;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            samp <= 3'b111;
        end else if (tick) begin
            cnt <= (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
            if (cnt >= SMP_FIRST && cnt <= SMP_LAST)
                samp <= {samp[1:0], din};
        end
    end

    assign voted     = urx_pkg::majority3(samp);
    assign shift_stb = run & tick & (cnt == SHIFT_AT);
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       fall,
    input  logic       shift_stb,
    input  logic       voted,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_par,
    output logic       run,
    output logic       post,
    output logic       busy,
    output logic [7:0] data,
    output rx_err_t    err
);
    rx_state_e state;
    par_mode_e par_q;
    logic      len8_q;
    logic [2:0] idx;
    logic [2:0] last_idx;
    logic       par_on;

    assign last_idx = len8_q ? 3'd7 : 3'd6;
    assign par_on   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            par_q  <= PAR_OFF;
            len8_q <= 1'b1;
            idx    <= '0;
            data   <= '0;
            err    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rx_en && fall) begin
                        state  <= ST_START;
                        len8_q <= cfg_len8;
                        par_q  <= par_mode_e'(cfg_par);
                        err    <= '0;
                    end
                end
                ST_START: begin
                    if (shift_stb) begin
                        if (voted) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                            idx   <= '0;
                            data  <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (shift_stb) begin
                        data[idx] <= voted;
                        if (idx == last_idx)
                            state <= par_on ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (shift_stb) begin
                        err.parity <= parity_bad(data, voted, par_q == PAR_ODD);
                        state      <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (shift_stb) begin
                        err.frame <= ~voted;
                        state     <= ST_POST;
                    end
                end
                ST_POST: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run  = (state == ST_START) || (state == ST_DATA) ||
                  (state == ST_PAR)   || (state == ST_STOP);
    assign post = (state == ST_POST);
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
    import urx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_par,
    input  logic       rd_strobe,
    output logic [7:0] rx_byte,
    output logic       rx_done,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    logic       line, fall, run, post, busy, voted, shift_stb, unread;
    logic [7:0] shreg;
    rx_err_t    pend;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(line), .fall(fall)
    );

    urx_sampler #(.OSR(OSR)) u_samp (
        .clk(clk), .rst(rst), .run(run), .tick(baud_tick), .din(line),
        .voted(voted), .shift_stb(shift_stb)
    );

    urx_frame u_frame (
        .clk(clk), .rst(rst), .rx_en(rx_en), .fall(fall),
        .shift_stb(shift_stb), .voted(voted), .cfg_len8(cfg_len8),
        .cfg_par(cfg_par), .run(run), .post(post), .busy(busy),
        .data(shreg), .err(pend)
    );

    // buffer and status are committed together with the completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte     <= '0;
            rx_done     <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            unread      <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (post) begin
                rx_byte     <= shreg;
                rx_done     <= 1'b1;
                err_frame   <= pend.frame;
                err_parity  <= pend.parity;
                err_overrun <= unread & ~rd_strobe;
                unread      <= 1'b1;
            end else if (rd_strobe) begin
                unread <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/urx_chk.sv
module urx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       busy,
    input logic       rx_done,
    input logic [7:0] rx_byte,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun
);
    AST_IDLE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rx_en) |=> !busy);                                   // R2
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable({err_frame, err_parity, err_overrun}));    // R10
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable(rx_byte));                                 // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);                                          // R12
    AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> rx_done);                                // R8
endmodule

bind uart_vote_rx urx_chk u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .busy(busy), .rx_done(rx_done),
    .rx_byte(rx_byte), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
);

// File: tb/sim_uart_vote_rx.sv
module sim_uart_vote_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;
    localparam int WD_LIMIT   = 100000;
    localparam int NV         = 12;

    // {len8, par[1:0], data[7:0], badpar, stop, exp_byte[7:0], exp_fe, exp_pe, pad}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 2'b00, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b00, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'b00, 8'hD3, 1'b0, 1'b1, 8'h53, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b01, 8'h37, 1'b0, 1'b1, 8'h37, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b01, 8'h37, 1'b1, 1'b1, 8'h37, 1'b0, 1'b1, 1'b0},
        {1'b1, 2'b10, 8'h5C, 1'b0, 1'b1, 8'h5C, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b10, 8'h5C, 1'b1, 1'b1, 8'h5C, 1'b0, 1'b1, 1'b0},
        {1'b0, 2'b10, 8'h7E, 1'b1, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0},
        {1'b1, 2'b00, 8'h81, 1'b0, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'b01, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b1, 1'b0, 1'b0},
        {1'b1, 2'b00, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_par = 2'b00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_done, err_frame, err_parity, err_overrun;

    int  n_chk = 0;
    int  n_bad = 0;
    int  done_cnt = 0;
    logic last_fe = 1'b0;
    logic fe_before_done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_vote_rx u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par(cfg_par), .rd_strobe(rd_strobe),
        .rx_byte(rx_byte), .rx_done(rx_done), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );

    always @(negedge clk) begin
        if (!rst && rx_done) begin
            done_cnt       = done_cnt + 1;
            fe_before_done = last_fe;
        end
        last_fe = err_frame;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic len8, input logic [1:0] par, input logic [7:0] d,
                              input logic badpar, input logic stopb,
                              input int gbit, input int g0, input int g1);
        logic bits [12];
        logic [7:0] dm;
        int n;
        n = 0;
        dm = len8 ? d : {1'b0, d[6:0]};
        bits[n] = 1'b0; n = n + 1;
        for (int i = 0; i < (len8 ? 8 : 7); i++) begin
            bits[n] = d[i]; n = n + 1;
        end
        if (par == 2'b01 || par == 2'b10) begin
            bits[n] = (^dm) ^ (par == 2'b10) ^ badpar; n = n + 1;
        end
        bits[n] = stopb; n = n + 1;
        cfg_len8 = len8;
        cfg_par  = par;
        for (int b = 0; b < n; b++)
            for (int c = 0; c < BIT_CLKS; c++) begin
                @(negedge clk);
                rxd = (b == gbit && c >= g0 && c <= g1) ? ~bits[b] : bits[b];
            end
        @(negedge clk);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic read_buf();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d0;
        logic [7:0] b0;
        logic [2:0] f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 byte", rx_byte, 8'h00);
        check("R1 flags", {4'b0, rx_done, err_frame, err_parity, err_overrun}, 8'h00);

        // table of frames: R4 R6 R7 R11 R12
        for (int i = 0; i < NV; i++) begin
            d0 = done_cnt;
            send_frame(VEC[i][23], VEC[i][22:21], VEC[i][20:13], VEC[i][12], VEC[i][11], -1, 0, 0);
            check("R12 one done", 8'(done_cnt - d0), 8'd1);
            check("R4 byte", rx_byte, VEC[i][10:3]);
            check("R6 frame err", {7'b0, err_frame}, {7'b0, VEC[i][2]});
            check("R7 parity err", {7'b0, err_parity}, {7'b0, VEC[i][1]});
            check("R9 no overrun", {7'b0, err_overrun}, 8'h00);
            if (i == NV - 1)
                check("R10 fe held until done", {7'b0, fe_before_done}, 8'h01);
            read_buf();
        end

        // R3 one corrupted sample per bit is outvoted
        send_frame(1'b1, 2'b00, 8'h55, 1'b0, 1'b1, 1, 8, 8);
        check("R3 single glitch bit0", rx_byte, 8'h55);
        read_buf();
        send_frame(1'b1, 2'b00, 8'h55, 1'b0, 1'b1, 4, 7, 7);
        check("R3 single glitch bit3", rx_byte, 8'h55);
        read_buf();
        send_frame(1'b1, 2'b00, 8'h55, 1'b0, 1'b1, 1, 6, 10);
        check("R3 full-window glitch flips bit0", rx_byte, 8'h54);
        read_buf();

        // R5 short start pulse is rejected
        d0 = done_cnt; b0 = rx_byte; f0 = {err_frame, err_parity, err_overrun};
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R5 no done", 8'(done_cnt - d0), 8'd0);
        check("R5 byte kept", rx_byte, b0);
        check("R5 flags kept", {5'b0, err_frame, err_parity, err_overrun}, {5'b0, f0});
        send_frame(1'b1, 2'b00, 8'h96, 1'b0, 1'b1, -1, 0, 0);
        check("R5 next frame ok", rx_byte, 8'h96);
        read_buf();

        // R2 receive disabled
        rx_en = 1'b0;
        d0 = done_cnt;
        send_frame(1'b1, 2'b00, 8'h11, 1'b0, 1'b1, -1, 0, 0);
        check("R2 no done when disabled", 8'(done_cnt - d0), 8'd0);
        check("R2 byte kept", rx_byte, 8'h96);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(1'b1, 2'b00, 8'h22, 1'b0, 1'b1, -1, 0, 0);
        check("R2 enabled frame", rx_byte, 8'h22);
        read_buf();

        // R8 overrun, R9 read clears
        send_frame(1'b1, 2'b00, 8'h10, 1'b0, 1'b1, -1, 0, 0);
        send_frame(1'b1, 2'b00, 8'h20, 1'b0, 1'b1, -1, 0, 0);
        check("R8 overrun set", {7'b0, err_overrun}, 8'h01);
        check("R8 overwritten", rx_byte, 8'h20);
        repeat (10) @(negedge clk);
        check("R11 overrun held", {7'b0, err_overrun}, 8'h01);
        read_buf();
        send_frame(1'b1, 2'b00, 8'h30, 1'b0, 1'b1, -1, 0, 0);
        check("R9 overrun cleared", {7'b0, err_overrun}, 8'h00);
        check("R9 byte", rx_byte, 8'h30);

        finish_run();
    end
endmodule